// File: doc/BRIEF.md
# Flash Thermometer Code Encoder

This block sits behind the comparator bank of a 4-bit flash converter. It takes the 15 comparator decisions as a thermometer vector and returns a registered 4-bit word. Bit 0 of the vector belongs to the comparator with the lowest threshold. A bit is 1 when the analog input lies above that comparator's threshold. The output value counts the comparators that are off, so an input at the top reference gives the smallest code.

Conversion takes two rising edges of the convert clock. The first edge captures the comparator vector. The second edge runs that vector through a majority-vote bubble filter, counts its zeros, applies the selected output format and loads the result into the output register. Two active-low format inputs invert the most significant bit and the three lower bits independently. Together they give four formats: true binary, inverted binary, true offset two's complement and inverted offset two's complement.

Top module: `flash_thermo_encoder`

## Requirements
- R1: Bit i of `thermo_i` is comparator i, where bit 0 has the lowest threshold, and a 1 means the input is above that threshold.
- R2: With both format inputs at 1 (true binary), a valid thermometer vector with N ones produces `data_o` = 15 − N, which is the number of zero bits.
- R3: An all-ones vector (input at the top reference) produces 0000 in true binary.
- R4: Before counting, each bit is replaced by the majority of itself and its two neighbours. The neighbour below bit 0 is taken as 1 and the neighbour above bit 14 is taken as 0. As a result, a single flipped bit that is at least two positions away from the 1-to-0 transition yields the same code as the clean vector, and a valid vector passes through unchanged.
- R5: A vector sampled at rising edge k appears on `data_o` after edge k+1. `data_o` changes only on a rising edge.
- R6: An all-zeros vector (input at or below the bottom reference) produces 1111 in true binary. The code does not wrap.
- R7: `msb_inv_n` = 0 inverts `data_o[3]` and `lsb_inv_n` = 0 inverts `data_o[2:0]`. For an all-ones vector this gives 1000 with only `msb_inv_n` low, 0111 with only `lsb_inv_n` low, and 1111 with both low.
- R8: The format inputs are sampled on the same edge that loads `data_o`, so a format change takes effect at the next output update.
- R9: While synchronous `rst` is high, `data_o` is cleared to 0000 regardless of the format inputs, and the sample stage is cleared to all zeros. The first update after reset is therefore the formatted full-scale-bottom code (1111 in true binary).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Convert clock; every rising edge samples and updates |
| rst | input | 1 | Synchronous reset, active high |
| thermo_i | input | 15 | Comparator thermometer vector, bit 0 lowest threshold |
| msb_inv_n | input | 1 | Active-low invert for the MSB |
| lsb_inv_n | input | 1 | Active-low invert for the three LSBs |
| data_o | output | 4 | Registered encoded word |

## Verification
The bench targets both ends of the scale. A counter that wrapped there would report 0000 for an all-off vector or 1111 for an all-on vector. The bench places bubbles at bit 0 and bit 14, where a wrong boundary value in the filter would shift the code by one. It also places bubbles deep inside both the ones region and the zeros region, where a missing filter would miscount. It steps the vector and the format inputs one edge apart. This exposes a design that skips the sample stage, since its output would arrive one update early, and a design that registers the format inputs one stage too soon, since its format would lag by one update.

// File: rtl/flash_enc_pkg.sv
package flash_enc_pkg;

  // Majority of three votes.
  function automatic logic vote3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  // Selective inversion of the MSB and of the remaining low bits.
  function automatic logic [3:0] shape4(input logic [3:0] code,
                                        input logic msb_keep,
                                        input logic lsb_keep);
    logic [3:0] r;
    r[3]   = code[3] ^ ~msb_keep;
    r[2:0] = code[2:0] ^ {3{~lsb_keep}};
    return r;
  endfunction

endpackage

// File: rtl/fenc_bubble_fix.sv
module fenc_bubble_fix #(
  parameter int COMP_N = 15
) (
  input  logic [COMP_N-1:0] raw_i,
  output logic [COMP_N-1:0] fixed_o
);
  import flash_enc_pkg::*;

  logic [COMP_N+1:0] padded;
  assign padded = {1'b0, raw_i, 1'b1};

  for (genvar i = 0; i < COMP_N; i++) begin : g_vote
    assign fixed_o[i] = vote3(padded[i], padded[i+1], padded[i+2]);
  end

endmodule

// File: rtl/fenc_zero_count.sv
module fenc_zero_count #(
  parameter int COMP_N = 15,
  parameter int CNT_W  = 4
) (
  input  logic [COMP_N-1:0] vec_i,
  output logic [CNT_W-1:0]  zeros_o
);

  always_comb begin
    zeros_o = '0;
    for (int i = 0; i < COMP_N; i++) begin
      zeros_o = zeros_o + {{(CNT_W-1){1'b0}}, ~vec_i[i]};
    end
  end

endmodule

// File: rtl/fenc_format.sv
module fenc_format #(
  parameter int OUT_W = 4
) (
  input  logic [OUT_W-1:0] code_i,
  input  logic             msb_inv_n,
  input  logic             lsb_inv_n,
  output logic [OUT_W-1:0] word_o
);

  assign word_o[OUT_W-1]   = code_i[OUT_W-1] ^ ~msb_inv_n;
  assign word_o[OUT_W-2:0] = code_i[OUT_W-2:0] ^ {(OUT_W-1){~lsb_inv_n}};

endmodule

// File: rtl/flash_thermo_encoder.sv
module flash_thermo_encoder #(
  parameter int OUT_W = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [(1<<OUT_W)-2:0] thermo_i,
  input  logic                  msb_inv_n,
  input  logic                  lsb_inv_n,
  output logic [OUT_W-1:0]      data_o
);
  localparam int COMP_N = (1 << OUT_W) - 1;

  logic [COMP_N-1:0] samp_q;
  logic [COMP_N-1:0] fixed_vec;
  logic [OUT_W-1:0]  zero_cnt;
  logic [OUT_W-1:0]  fmt_word;
  logic              bubble_seen;

  // Stage 1: capture comparator decisions.
  always_ff @(posedge clk) begin
    if (rst) samp_q <= '0;
    else     samp_q <= thermo_i;
  end

  fenc_bubble_fix #(.COMP_N(COMP_N)) u_fix (
    .raw_i  (samp_q),
    .fixed_o(fixed_vec)
  );

  assign bubble_seen = |(fixed_vec ^ samp_q);

  fenc_zero_count #(.COMP_N(COMP_N), .CNT_W(OUT_W)) u_cnt (
    .vec_i  (fixed_vec),
    .zeros_o(zero_cnt)
  );

  fenc_format #(.OUT_W(OUT_W)) u_fmt (
    .code_i   (zero_cnt),
    .msb_inv_n(msb_inv_n),
    .lsb_inv_n(lsb_inv_n),
    .word_o   (fmt_word)
  );

  // Stage 2: output register.
  always_ff @(posedge clk) begin
    if (rst) data_o <= '0;
    else     data_o <= fmt_word;
  end

endmodule

// File: rtl/flash_thermo_encoder_chk.sv
module flash_thermo_encoder_chk #(
  parameter int OUT_W = 4
) (
  input logic                  clk,
  input logic                  rst,
  input logic [(1<<OUT_W)-2:0] thermo_i,
  input logic                  msb_inv_n,
  input logic                  lsb_inv_n,
  input logic [OUT_W-1:0]      data_o,
  input logic [(1<<OUT_W)-2:0] samp_q,
  input logic [(1<<OUT_W)-2:0] fixed_vec,
  input logic                  bubble_seen
);
  localparam int COMP_N = (1 << OUT_W) - 1;

  logic [1:0] run_q;
  always_ff @(posedge clk) begin
    if (rst)              run_q <= '0;
    else if (run_q != 2'd3) run_q <= run_q + 2'd1;
  end

  AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (data_o == '0)); // R9

  AST_TOP_CODE: assert property (@(posedge clk) disable iff (rst)
    (run_q >= 2'd2 && $past(thermo_i, 2) == '1 && $past(msb_inv_n) && $past(lsb_inv_n))
      |-> (data_o == '0)); // R3

  AST_BOTTOM_CODE: assert property (@(posedge clk) disable iff (rst)
    (run_q >= 2'd2 && $past(thermo_i, 2) == '0 && $past(msb_inv_n) && $past(lsb_inv_n))
      |-> (data_o == '1)); // R6

  AST_TRUE_COUNT: assert property (@(posedge clk) disable iff (rst)
    (run_q >= 2'd2 && (($past(thermo_i, 2) & ($past(thermo_i, 2) + 1'b1)) == '0)
     && $past(msb_inv_n) && $past(lsb_inv_n))
      |-> (data_o == OUT_W'(COMP_N - $countones($past(thermo_i, 2))))); // R2

  AST_HOLD_STEADY: assert property (@(posedge clk) disable iff (rst)
    (run_q == 2'd3 && $past(thermo_i, 2) == $past(thermo_i, 3)
     && $past(msb_inv_n) == $past(msb_inv_n, 2) && $past(lsb_inv_n) == $past(lsb_inv_n, 2))
      |-> $stable(data_o)); // R5

  AST_FIX_TRANSPARENT: assert property (@(posedge clk) disable iff (rst)
    ((samp_q & (samp_q + 1'b1)) == '0) |-> (!bubble_seen && fixed_vec == samp_q)); // R4

endmodule

bind flash_thermo_encoder flash_thermo_encoder_chk #(.OUT_W(OUT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .thermo_i   (thermo_i),
  .msb_inv_n  (msb_inv_n),
  .lsb_inv_n  (lsb_inv_n),
  .data_o     (data_o),
  .samp_q     (samp_q),
  .fixed_vec  (fixed_vec),
  .bubble_seen(bubble_seen)
);

// File: tb/flash_thermo_encoder_bench.sv
module flash_thermo_encoder_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [14:0] thermo = '0;
  logic        mi_n = 1'b1;
  logic        li_n = 1'b1;
  logic [3:0]  data_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  flash_thermo_encoder u_flash_thermo_encoder (
    .clk(clk), .rst(rst), .thermo_i(thermo),
    .msb_inv_n(mi_n), .lsb_inv_n(li_n), .data_o(data_o)
  );

  function automatic logic [14:0] therm(input int n);
    logic [14:0] v = '0;
    for (int i = 0; i < n; i++) v[i] = 1'b1;
    return v;
  endfunction

  // Expected code: clean vector by neighbour vote, then 15 minus ones.
  function automatic logic [3:0] ref_code(input logic [14:0] v, input logic m, input logic l);
    logic [16:0] p;
    int ones;
    logic [3:0] c;
    p = {1'b0, v, 1'b1};
    ones = 0;
    for (int i = 1; i <= 15; i++)
      if (int'(p[i-1]) + int'(p[i]) + int'(p[i+1]) >= 2) ones++;
    c = 4'(15 - ones);
    if (!m) c = {~c[3], c[2:0]};
    if (!l) c = {c[3], ~c[2:0]};
    return c;
  endfunction

  logic [14:0] m_samp;
  logic [3:0]  m_out;
  always @(posedge clk) begin
    if (rst) begin
      m_samp <= '0;
      m_out  <= '0;
    end else begin
      m_samp <= thermo;
      m_out  <= ref_code(m_samp, mi_n, li_n);
    end
  end

  task automatic check(input string tag, input logic [3:0] exp);
    checks++;
    if (data_o !== exp) begin
      errors++;
      $display("FAIL %s: data_o=%b expected=%b", tag, data_o, exp);
    end
  endtask

  task automatic step(input logic [14:0] v, input logic m, input logic l, input string tag);
    @(negedge clk);
    check(tag, m_out);
    thermo = v; mi_n = m; li_n = l;
  endtask

  initial begin
    repeat (1500000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: data_o=%b expected=done", data_o);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1044));
    // R9 reset behaviour
    thermo = '1; mi_n = 1'b0; li_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R9 reset clear", 4'b0000);
    @(negedge clk); rst = 1'b0;
    @(negedge clk); check("R9 first update after reset", 4'b0000); // samp cleared, fmt 00 inverts 1111
    @(negedge clk); // output now from thermo='1 with both invert => 1111
    check("R9 follow-on", 4'b1111);

    // R1 R2 R3 R6 R7 sweep of all clean patterns under each format
    for (int f = 0; f < 4; f++) begin
      for (int n = 0; n <= 15; n++) begin
        string tg;
        tg = (n == 15) ? "R3 top" : (n == 0) ? "R6 bottom" : (f == 3) ? "R2 true binary" : "R7 format";
        for (int k = 0; k < 3; k++) step(therm(n), f[1], f[0], tg);
        @(negedge clk);
        check({tg, " R1 sweep"}, ref_code(therm(n), f[1], f[0]));
      end
    end

    // R7 literal top codes
    for (int k = 0; k < 3; k++) step('1, 1'b0, 1'b1, "R7");
    @(negedge clk); check("R7 msb-only top", 4'b1000);
    for (int k = 0; k < 3; k++) step('1, 1'b1, 1'b0, "R7");
    @(negedge clk); check("R7 lsb-only top", 4'b0111);
    for (int k = 0; k < 3; k++) step('1, 1'b0, 1'b0, "R7");
    @(negedge clk); check("R7 both top", 4'b1111);

    // R5 latency: N=3 steady, then N=10
    for (int k = 0; k < 3; k++) step(therm(3), 1'b1, 1'b1, "R5");
    @(negedge clk); check("R5 steady", 4'd12);
    thermo = therm(10);
    @(negedge clk); check("R5 sample edge holds old word", 4'd12);
    @(negedge clk); check("R5 next edge shows new word", 4'd5);

    // R8 format change takes effect at next update
    for (int k = 0; k < 3; k++) step('1, 1'b1, 1'b1, "R8");
    @(negedge clk); check("R8 before change", 4'b0000);
    mi_n = 1'b0;
    @(negedge clk); check("R8 after one update", 4'b1000);

    // R4 directed bubbles at boundaries and deep inside
    for (int k = 0; k < 3; k++) step(therm(15) & ~15'h0001, 1'b1, 1'b1, "R4");
    @(negedge clk); check("R4 bubble bit0", 4'd0);
    for (int k = 0; k < 3; k++) step(15'h4000, 1'b1, 1'b1, "R4");
    @(negedge clk); check("R4 bubble bit14", 4'd15);
    for (int k = 0; k < 3; k++) step(therm(9) & ~15'h0010, 1'b1, 1'b1, "R4");
    @(negedge clk); check("R4 zero inside ones", 4'd6);
    for (int k = 0; k < 3; k++) step(therm(4) | 15'h0400, 1'b1, 1'b1, "R4");
    @(negedge clk); check("R4 one inside zeros", 4'd11);

    // Random mix: clean, single isolated bubbles, format changes
    for (int k = 0; k < 2000; k++) begin
      int n;
      int j;
      logic [14:0] v;
      n = int'($urandom_range(0, 15));
      v = therm(n);
      if ($urandom_range(0, 1) == 1) begin
        j = int'($urandom_range(0, 14));
        if (j <= n - 3 || j >= n + 2) v[j] = ~v[j];
      end
      step(v, ($urandom_range(0, 7) != 0) ? mi_n : ~mi_n,
              ($urandom_range(0, 7) != 0) ? li_n : ~li_n, "R4 random");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule